// File: doc/BRIEF.md
# Timer with Shared Assignable Prescaler

An 8-bit up-counter that counts ticks of a selectable source. The source is either a one-cycle instruction tick or a transition of an external pin. Pin edges are found after a two-flop synchroniser, and the active edge is selectable. A single prescaler counter serves one of two clients at a time. It either divides the source ticks before they reach the counter, or divides the watchdog base ticks before they reach the watchdog count. A 3-bit rate code sets the division. The same code gives the counter twice the ratio it gives the watchdog.

A bus write loads the counter. A wrap from 255 to 0 raises a one-cycle overflow pulse toward interrupt logic. A clear input restarts the watchdog, and the timeout output is high while the watchdog count sits at its maximum. All configuration arrives on a 6-bit input with this layout:

- bits 2:0 hold the rate code.
- bit 3 selects the prescaler owner.
- bit 4 selects the edge.
- bit 5 selects the source.

Top module: `tmr_prescaled_timer`

## Requirements
- R1: After reset, count_o is 0, ovf_o is 0 and wdt_timeout_o is 0.
- R2: With cfg[3]=0 (prescaler owned by the counter) and rate code n=cfg[2:0], count_o advances by one once every 2^(n+1) source ticks, from 1:2 (n=0) to 1:256 (n=7).
- R3: With cfg[3]=1, count_o advances by one on every source tick, undivided.
- R4: With cfg[3]=1, the watchdog count advances once every 2^n ticks of wdt_tick (1:1 to 1:128). With cfg[3]=0 it advances on every wdt_tick.
- R5: The source is instr_tick when cfg[5]=0. When cfg[5]=1 it is ext_pin: rising transitions count when cfg[4]=0 and falling transitions when cfg[4]=1, and instr_tick is then ignored. A pin transition set up before clock edge k changes count_o at edge k+2.
- R6: count_o wraps from 255 to 0, and ovf_o is 1 for exactly the cycle in which count_o shows that 0.
- R7: cnt_wr loads cnt_wdata into count_o at the next edge, taking priority over any increment in that cycle. When cfg[3]=0 it also zeroes the prescaler.
- R8: wdt_clr zeroes the watchdog count at the next edge, taking priority over wdt_tick. When cfg[3]=1 it also zeroes the prescaler.
- R9: wdt_timeout_o is 1 while the watchdog count equals 2^WDT_W-1. The count then holds at that value until wdt_clr.
- R10: A change of cfg[3] between consecutive cycles zeroes the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_tick | input | 1 | Internal count tick, one cycle wide |
| ext_pin | input | 1 | Asynchronous external count input |
| cfg | input | 6 | Configuration: [5] source, [4] edge, [3] prescaler owner, [2:0] rate |
| cnt_wr | input | 1 | Bus write strobe for the counter |
| cnt_wdata | input | CNT_W | Bus write data for the counter |
| wdt_tick | input | 1 | Watchdog base tick |
| wdt_clr | input | 1 | Watchdog restart |
| count_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle wrap pulse |
| wdt_timeout_o | output | 1 | Watchdog expired |

## Verification
The prescaler count cannot be seen at the ports, so its clears (R7, R8, R10) are hard to observe. The stimulus first leaves the prescaler part-way through a divide-by-8 period, then applies the clearing event. It then gives too few ticks to complete a period from zero, but enough to complete one from the old value, so a missed clear shows up as an extra count. The random phase changes the owner bit, the edge select and the rate while ticks are still flowing. A cycle-accurate bench model checks every cycle of it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int RATE_W = 3;

    // Layout of the configuration input, MSB first.
    typedef struct packed {
        logic              src_ext;   // 1: external pin, 0: instruction tick
        logic              edge_fall; // 1: falling pin edges, 0: rising
        logic              ps_to_wdt; // 1: prescaler serves watchdog
        logic [RATE_W-1:0] rate;
    } tmr_cfg_t;

    localparam int CFG_W = $bits(tmr_cfg_t);
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin};
        st_d.prev = st_q.sh[STAGES-1];
        rise      = st_q.sh[STAGES-1] & ~st_q.prev;
        fall      = ~st_q.sh[STAGES-1] & st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick,
    input  logic              wdt_tick,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              cnt_wr,
    input  logic              wdt_clr,
    output logic              cnt_step,
    output logic              wdt_step
);
    localparam int PS_W = 1 << RATE_W;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            owner;
    } ps_t;

    ps_t             st_d, st_q;
    logic [PS_W:0]   tap;
    logic [PS_W-1:0] wmask;
    logic [PS_W-1:0] cmask;

    always_comb begin
        tap   = {{PS_W{1'b0}}, 1'b1} << rate;
        wmask = PS_W'(tap - (PS_W+1)'(1));
        cmask = {wmask[PS_W-2:0], 1'b1};

        cnt_step = to_wdt ? src_tick
                          : (src_tick && ((st_q.ps & cmask) == cmask));
        wdt_step = to_wdt ? (wdt_tick && ((st_q.ps & wmask) == wmask))
                          : wdt_tick;

        st_d       = st_q;
        st_d.owner = to_wdt;
        if (to_wdt != st_q.owner)            st_d.ps = '0;
        else if (!to_wdt && cnt_wr)          st_d.ps = '0;
        else if (to_wdt && wdt_clr)          st_d.ps = '0;
        else if (!to_wdt && src_tick)        st_d.ps = st_q.ps + PS_W'(1);
        else if (to_wdt && wdt_tick)         st_d.ps = st_q.ps + PS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_prescaled_timer.sv
module tmr_prescaled_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int WDT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_tick,
    input  logic             ext_pin,
    input  logic [CFG_W-1:0] cfg,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             wdt_tick,
    input  logic             wdt_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             wdt_timeout_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [WDT_W-1:0] wdt;
        logic             ovf;
    } tmr_t;

    tmr_t     st_d, st_q;
    tmr_cfg_t cfg_s;
    logic     pin_rise, pin_fall, src_tick;
    logic     cnt_step, wdt_step;

    assign cfg_s = tmr_cfg_t'(cfg);

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    tmr_prescaler ps_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_tick(src_tick),
        .wdt_tick(wdt_tick),
        .to_wdt  (cfg_s.ps_to_wdt),
        .rate    (cfg_s.rate),
        .cnt_wr  (cnt_wr),
        .wdt_clr (wdt_clr),
        .cnt_step(cnt_step),
        .wdt_step(wdt_step)
    );

    always_comb begin
        src_tick = cfg_s.src_ext ? (cfg_s.edge_fall ? pin_fall : pin_rise)
                                 : instr_tick;
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (cnt_wr) begin
            st_d.cnt = cnt_wdata;
        end else if (cnt_step) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.ovf = &st_q.cnt;
        end
        if (wdt_clr)
            st_d.wdt = '0;
        else if (wdt_step && !(&st_q.wdt))
            st_d.wdt = st_q.wdt + WDT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o       = st_q.cnt;
    assign ovf_o         = st_q.ovf;
    assign wdt_timeout_o = &st_q.wdt;
endmodule

// File: rtl/tmr_timer_chk.sv
module tmr_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             wdt_clr,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             wdt_timeout_o
);
    // R6
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == '0));

    // R6
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);

    // R7
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_o == $past(cnt_wdata)));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> ((count_o == $past(count_o)) ||
                     (count_o == CNT_W'($past(count_o) + CNT_W'(1)))));

    // R8
    wdt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr |=> !wdt_timeout_o);

    // R9
    timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout_o && !wdt_clr) |=> wdt_timeout_o);
endmodule

bind tmr_prescaled_timer tmr_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_wr       (cnt_wr),
    .cnt_wdata    (cnt_wdata),
    .wdt_clr      (wdt_clr),
    .count_o      (count_o),
    .ovf_o        (ovf_o),
    .wdt_timeout_o(wdt_timeout_o)
);

// File: tb/tmr_prescaled_timer_tb_top.sv
module tmr_prescaled_timer_tb_top;
    localparam int CNT_W = 8;
    localparam int WDT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_tick = 1'b0;
    logic             ext_pin = 1'b0;
    logic [5:0]       cfg = '0;
    logic             cnt_wr = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic             wdt_tick = 1'b0;
    logic             wdt_clr = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             ovf_o;
    logic             wdt_timeout_o;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // reference state
    logic             m_s0 = 0, m_s1 = 0, m_prev = 0, m_owner = 0;
    logic [7:0]       m_ps = '0;
    logic [CNT_W-1:0] m_cnt = '0;
    logic [WDT_W-1:0] m_wdt = '0;
    logic             m_ovf = 0;

    always #10 clk = ~clk;

    tmr_prescaled_timer #(.CNT_W(CNT_W), .WDT_W(WDT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_tick(instr_tick), .ext_pin(ext_pin),
        .cfg(cfg), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .wdt_tick(wdt_tick),
        .wdt_clr(wdt_clr), .count_o(count_o), .ovf_o(ovf_o),
        .wdt_timeout_o(wdt_timeout_o)
    );

    function automatic logic [7:0] wdt_mask(logic [2:0] n);
        return 8'((9'd1 << n) - 9'd1);
    endfunction

    function automatic logic [7:0] cnt_mask(logic [2:0] n);
        return 8'((9'd2 << n) - 9'd1);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin : ref_model
        logic rise, fall, src, cst, wst, asg;
        if (!rst_n) begin
            m_s0 = 0; m_s1 = 0; m_prev = 0; m_owner = 0;
            m_ps = '0; m_cnt = '0; m_wdt = '0; m_ovf = 0;
        end else begin
            rise = m_s1 & ~m_prev;
            fall = ~m_s1 & m_prev;
            src  = cfg[5] ? (cfg[4] ? fall : rise) : instr_tick;
            asg  = cfg[3];
            cst  = asg ? src : (src && ((m_ps & cnt_mask(cfg[2:0])) == cnt_mask(cfg[2:0])));
            wst  = asg ? (wdt_tick && ((m_ps & wdt_mask(cfg[2:0])) == wdt_mask(cfg[2:0])))
                       : wdt_tick;
            m_ovf = 0;
            if (cnt_wr) m_cnt = cnt_wdata;
            else if (cst) begin
                m_ovf = (m_cnt == '1);
                m_cnt = m_cnt + 1'b1;
            end
            if (wdt_clr) m_wdt = '0;
            else if (wst && m_wdt != '1) m_wdt = m_wdt + 1'b1;
            if (asg != m_owner)         m_ps = '0;
            else if (!asg && cnt_wr)    m_ps = '0;
            else if (asg && wdt_clr)    m_ps = '0;
            else if (!asg && src)       m_ps = m_ps + 1'b1;
            else if (asg && wdt_tick)   m_ps = m_ps + 1'b1;
            m_owner = asg;
            m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_pin;
        end
    end

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, "model count", int'(count_o), int'(m_cnt));
            check(cur_req, "model ovf", int'(ovf_o), int'(m_ovf));
            check(cur_req, "model timeout", int'(wdt_timeout_o), int'(m_wdt == '1));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(logic [7:0] v);
        cnt_wr = 1; cnt_wdata = v; step(1); cnt_wr = 0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        step(3);
        rst_n = 1;
        step(1);
        cur_req = "R1";
        check("R1", "reset count", int'(count_o), 0);
        check("R1", "reset ovf", int'(ovf_o), 0);
        check("R1", "reset timeout", int'(wdt_timeout_o), 0);

        // R2: divide by 4 on rate code 1
        cur_req = "R2";
        cfg = 6'b000_001; load(8'd0);
        instr_tick = 1; step(8); instr_tick = 0;
        check("R2", "count after 8 ticks /4", int'(count_o), 2);

        // R3: undivided when prescaler owned by watchdog
        cur_req = "R3";
        cfg = 6'b001_000; load(8'd0);
        instr_tick = 1; step(5); instr_tick = 0;
        check("R3", "count after 5 ticks", int'(count_o), 5);

        // R6: wrap and overflow pulse
        cur_req = "R6";
        load(8'd254);
        instr_tick = 1; step(1);
        check("R6", "count 255", int'(count_o), 255);
        check("R6", "no ovf at 255", int'(ovf_o), 0);
        step(1);
        check("R6", "wrapped count", int'(count_o), 0);
        check("R6", "ovf on wrap", int'(ovf_o), 1);
        instr_tick = 0; step(1);
        check("R6", "ovf dropped", int'(ovf_o), 0);

        // R7: write beats increment
        cur_req = "R7";
        instr_tick = 1; cnt_wr = 1; cnt_wdata = 8'd10; step(1);
        cnt_wr = 0; instr_tick = 0;
        check("R7", "write priority", int'(count_o), 10);

        // R5: external pin, edge select, latency, instr_tick ignored
        cur_req = "R5";
        cfg = 6'b101_000; load(8'd0);
        instr_tick = 1;
        ext_pin = 1; step(2);
        check("R5", "rise not yet seen", int'(count_o), 0);
        step(1);
        check("R5", "rise counted at third edge", int'(count_o), 1);
        ext_pin = 0; step(4);
        check("R5", "fall ignored on rising select", int'(count_o), 1);
        cfg = 6'b111_000; step(1);
        ext_pin = 1; step(4);
        check("R5", "rise ignored on falling select", int'(count_o), 1);
        ext_pin = 0; step(3);
        check("R5", "fall counted", int'(count_o), 2);
        instr_tick = 0;

        // R10: owner change clears prescaler
        cur_req = "R10";
        cfg = 6'b000_010; load(8'd0);
        instr_tick = 1; step(5); instr_tick = 0;
        check("R10", "no step before 8", int'(count_o), 0);
        cfg = 6'b001_010; step(1);
        cfg = 6'b000_010; step(1);
        instr_tick = 1; step(3); instr_tick = 0;
        check("R10", "prescaler restarted", int'(count_o), 0);

        // R7: write clears prescaler when owned by counter
        cur_req = "R7";
        instr_tick = 1; step(2); instr_tick = 0;
        load(8'd0);
        instr_tick = 1; step(3); instr_tick = 0;
        check("R7", "prescaler cleared by write", int'(count_o), 0);
        instr_tick = 1; step(5); instr_tick = 0;
        check("R2", "step after 8 ticks", int'(count_o), 1);

        // R9 / R8: watchdog undivided
        cur_req = "R9";
        cfg = 6'b000_000;
        wdt_clr = 1; step(1); wdt_clr = 0;
        wdt_tick = 1; step(14);
        check("R9", "not yet expired", int'(wdt_timeout_o), 0);
        step(1);
        check("R9", "expired at max", int'(wdt_timeout_o), 1);
        step(5);
        check("R9", "timeout held", int'(wdt_timeout_o), 1);
        cur_req = "R8";
        wdt_clr = 1; step(1); wdt_clr = 0;
        check("R8", "clear with tick active", int'(wdt_timeout_o), 0);
        wdt_tick = 0;

        // R4: watchdog divided by 2 on rate code 1
        cur_req = "R4";
        cfg = 6'b001_001;
        wdt_clr = 1; step(1); wdt_clr = 0;
        wdt_tick = 1; step(29);
        check("R4", "29 ticks /2 short of max", int'(wdt_timeout_o), 0);
        step(1);
        check("R4", "30 ticks /2 reaches max", int'(wdt_timeout_o), 1);
        wdt_tick = 0;
        wdt_clr = 1; step(1); wdt_clr = 0;

        // random mix, checked every cycle against the model
        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            instr_tick = 1'($urandom % 2);
            if ($urandom % 64 == 0) cfg = 6'($urandom);
            cnt_wr    = ($urandom % 32 == 0);
            cnt_wdata = 8'($urandom);
            wdt_tick  = ($urandom % 3 == 0);
            wdt_clr   = ($urandom % 40 == 0);
            if ($urandom % 5 == 0) ext_pin = ~ext_pin;
            step(1);
        end
        instr_tick = 0; cnt_wr = 0; wdt_tick = 0; wdt_clr = 0;
        step(2);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule